// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block is the producing end of an interrupt queue that lives in system memory. Interrupt sources hand it 128-bit vectors one at a time. Each accepted vector is stored as four consecutive 32-bit memory words into a power-of-two ring, starting at a programmable base. A byte-granular write pointer advances by one 16-byte slot per stored vector. The host consumes entries and reports its progress through a read pointer register.

When storing a vector would make the write pointer catch up with the read pointer, the block still stores it. It then raises a sticky overflow flag in the top bit of the readable write pointer, so the host knows that the oldest surviving entry sits one slot past the write pointer. That flag is cleared only through a dedicated clear bit. Optionally, every pointer update is also written to a mirror location in memory. An interrupt line stays high while the ring holds unread entries.

Registers are reached through a plain word-wide write/read port, with the read data returned combinationally. Memory is reached through a one-word-per-cycle write port that never stalls.

Top module: `ivr_ring_writer`

## Requirements
- R1: After reset the control, base, pointer and mirror-address registers read zero. The ring is disabled, `vec_ready`, `mem_we` and `irq_out` are low, and the write-pointer register reads 0.
- R2: An accepted vector is written as four words on four consecutive cycles, bits [31:0] first. The words go to the entry address plus 0, 4, 8 and 12.
- R3: The base register (index 1) holds the ring address divided by 256. The entry address is base*256 plus the write pointer at the moment the vector is accepted.
- R4: Control bits [5:1] give log2 of the ring size in 32-bit words, clamped to the range 2..MAX_LOG2. The write pointer advances by 16 after each entry and wraps with the mask (4 * 2^size) - 1. Writes to the read pointer (index 2) are masked the same way.
- R5: When the advanced write pointer equals the read pointer, the entry is still written and bit 31 of the write-pointer register (index 3, pointer in the low bits) becomes 1. It stays 1 across later entries.
- R6: While the clear bit (control bit 6) is 1, the overflow flag reads 0 one cycle later and no new overflow is recorded. After the bit returns to 0 the flag stays 0 until a fresh overflow occurs.
- R7: With control bit 7 set, each entry is followed on the next cycle by one extra word write. It goes to the mirror address {index 5 [7:0], index 4} and carries the write-pointer register value after the update.
- R8: `irq_out` is high exactly when control bit 8 (interrupt enable) and bit 0 (ring enable) are both 1 and either the pointers differ or the overflow flag is set.
- R9: Writing control bit 0 from 1 to 0 resets the write pointer, the read pointer and the overflow flag to zero. While the ring is disabled, offered vectors are neither accepted nor written.
- R10: `vec_ready` is high only when the ring is enabled and no entry is being written. It is low during the word writes of an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 base, 2 read ptr, 3 write ptr, 4 mirror low, 5 mirror high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| vec_valid | input | 1 | A vector is offered |
| vec_data | input | 128 | Offered interrupt vector |
| vec_ready | output | 1 | Vector accepted on this edge when `vec_valid` is high |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Byte address of the memory word |
| mem_wdata | output | 32 | Memory word data |
| irq_out | output | 1 | Unread entries pending |

## Verification
The bench fills a four-slot ring until the write pointer lands on the read pointer. A design that skipped the write, or that missed or dropped the sticky flag, would show a wrong memory trace or a wrong bit 31. It holds the clear bit through a would-be overflow to catch a design that records overflow regardless of the clear control. It also programs a two-slot ring to expose a wrong wrap mask, and disables the ring with entries pending to catch pointers that survive the disable. The mirror write is compared against the updated pointer, which a design that sampled the pointer one cycle early would get wrong.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_W0   = 3'd1,
        PH_W1   = 3'd2,
        PH_W2   = 3'd3,
        PH_W3   = 3'd4,
        PH_WB   = 3'd5
    } phase_e;

    // register indices
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_BASE = 3'd1;
    localparam logic [2:0] RA_RPTR = 3'd2;
    localparam logic [2:0] RA_WPTR = 3'd3;
    localparam logic [2:0] RA_WBLO = 3'd4;
    localparam logic [2:0] RA_WBHI = 3'd5;

    // control field positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SIZE_LSB = 1;
    localparam int CTRL_SIZE_W   = 5;
    localparam int CTRL_CLR_BIT  = 6;
    localparam int CTRL_WB_BIT   = 7;
    localparam int CTRL_IRQ_BIT  = 8;

    localparam int ENTRY_BYTES     = 16;
    localparam int WORD_BYTES      = 4;
    localparam int WORDS_PER_ENTRY = 4;
    localparam int BASE_SHIFT      = 8;
    localparam int VEC_W           = WORDS_PER_ENTRY * 32;

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int PTR_W    = 16,
    parameter int MAX_LOG2 = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [2:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic [PTR_W-1:0]             wptr_i,
    input  logic                         ovf_i,
    output logic                         ring_en_o,
    output logic                         irq_en_o,
    output logic                         wb_en_o,
    output logic                         ovf_clr_o,
    output logic [PTR_W-1:0]             mask_o,
    output logic [PTR_W-1:0]             rptr_o,
    output logic [ADDR_W-BASE_SHIFT-1:0] base_o,
    output logic [ADDR_W-1:0]            wb_addr_o,
    output logic                         disable_o
);
    localparam int BASE_W = ADDR_W - BASE_SHIFT;
    localparam int HI_W   = ADDR_W - 32;
    localparam int PAD_W  = 31 - PTR_W;
    localparam logic [CTRL_SIZE_W-1:0] SZ_MIN = CTRL_SIZE_W'(2);
    localparam logic [CTRL_SIZE_W-1:0] SZ_MAX = CTRL_SIZE_W'(MAX_LOG2);

    typedef struct packed {
        logic                   ring_en;
        logic [CTRL_SIZE_W-1:0] size;
        logic                   ovf_clr;
        logic                   wb_en;
        logic                   irq_en;
        logic [BASE_W-1:0]      base;
        logic [PTR_W-1:0]       rptr;
        logic [31:0]            wb_lo;
        logic [HI_W-1:0]        wb_hi;
    } regs_t;

    regs_t s_q, s_d;
    logic [CTRL_SIZE_W-1:0] eff_size;
    logic [PTR_W:0]         span;
    logic [PTR_W:0]         span_m1;

    // ring mask from the clamped size field
    always_comb begin
        if (s_q.size < SZ_MIN)      eff_size = SZ_MIN;
        else if (s_q.size > SZ_MAX) eff_size = SZ_MAX;
        else                        eff_size = s_q.size;
        span    = {{PTR_W{1'b0}}, 1'b1} << (int'(eff_size) + 2);
        span_m1 = span - {{PTR_W{1'b0}}, 1'b1};
        mask_o  = span_m1[PTR_W-1:0];
    end

    always_comb begin
        s_d       = s_q;
        disable_o = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    s_d.ring_en = reg_wdata[CTRL_EN_BIT];
                    s_d.size    = reg_wdata[CTRL_SIZE_LSB +: CTRL_SIZE_W];
                    s_d.ovf_clr = reg_wdata[CTRL_CLR_BIT];
                    s_d.wb_en   = reg_wdata[CTRL_WB_BIT];
                    s_d.irq_en  = reg_wdata[CTRL_IRQ_BIT];
                    disable_o   = s_q.ring_en & ~reg_wdata[CTRL_EN_BIT];
                end
                RA_BASE: s_d.base  = BASE_W'(reg_wdata);
                RA_RPTR: s_d.rptr  = reg_wdata[PTR_W-1:0] & mask_o;
                RA_WBLO: s_d.wb_lo = reg_wdata;
                RA_WBHI: s_d.wb_hi = reg_wdata[HI_W-1:0];
                default: ;
            endcase
        end
        if (disable_o) s_d.rptr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = 32'({s_q.irq_en, s_q.wb_en, s_q.ovf_clr, s_q.size, s_q.ring_en});
            RA_BASE: reg_rdata = 32'(s_q.base);
            RA_RPTR: reg_rdata = 32'(s_q.rptr);
            RA_WPTR: reg_rdata = {ovf_i, {PAD_W{1'b0}}, wptr_i};
            RA_WBLO: reg_rdata = s_q.wb_lo;
            RA_WBHI: reg_rdata = 32'(s_q.wb_hi);
            default: reg_rdata = '0;
        endcase
    end

    assign ring_en_o = s_q.ring_en;
    assign irq_en_o  = s_q.irq_en;
    assign wb_en_o   = s_q.wb_en;
    assign ovf_clr_o = s_q.ovf_clr;
    assign rptr_o    = s_q.rptr;
    assign base_o    = s_q.base;
    assign wb_addr_o = {s_q.wb_hi, s_q.wb_lo};

endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
    import ivr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_en_i,
    input  logic             commit_i,
    input  logic             clear_i,
    input  logic             ovf_clr_i,
    input  logic [PTR_W-1:0] rptr_i,
    input  logic [PTR_W-1:0] mask_i,
    output logic [PTR_W-1:0] wptr_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic             ovf;
    } ptr_t;

    ptr_t             s_q, s_d;
    logic [PTR_W-1:0] nxt;

    always_comb begin
        s_d = s_q;
        nxt = (s_q.wptr + PTR_W'(ENTRY_BYTES)) & mask_i;
        if (commit_i && ring_en_i) begin
            s_d.wptr = nxt;
            // landing on the reader means the oldest slot was overwritten
            if (!ovf_clr_i && (nxt == rptr_i)) s_d.ovf = 1'b1;
        end
        if (ovf_clr_i) s_d.ovf = 1'b0;
        if (clear_i)   s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wptr_o = s_q.wptr;
    assign ovf_o  = s_q.ovf;

endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int PTR_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ring_en_i,
    input  logic                         wb_en_i,
    input  logic                         vec_valid_i,
    input  logic [VEC_W-1:0]             vec_data_i,
    input  logic [ADDR_W-BASE_SHIFT-1:0] base_i,
    input  logic [PTR_W-1:0]             wptr_i,
    input  logic                         ovf_i,
    input  logic [ADDR_W-1:0]            wb_addr_i,
    output logic                         vec_ready_o,
    output logic                         mem_we_o,
    output logic [ADDR_W-1:0]            mem_addr_o,
    output logic [31:0]                  mem_wdata_o,
    output logic                         commit_o,
    output phase_e                       phase_o
);
    localparam int PAD_W = 31 - PTR_W;

    typedef struct packed {
        phase_e            phase;
        logic [VEC_W-1:0]  hold;
        logic [ADDR_W-1:0] ent_addr;
    } seq_t;

    seq_t        s_q, s_d;
    logic [31:0] word_sel [WORDS_PER_ENTRY];
    logic [1:0]  widx;

    for (genvar g = 0; g < WORDS_PER_ENTRY; g++) begin : g_word
        assign word_sel[g] = s_q.hold[32*g +: 32];
    end

    always_comb begin
        case (s_q.phase)
            PH_W1:   widx = 2'd1;
            PH_W2:   widx = 2'd2;
            PH_W3:   widx = 2'd3;
            default: widx = 2'd0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        vec_ready_o = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        commit_o    = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                vec_ready_o = ring_en_i;
                if (ring_en_i && vec_valid_i) begin
                    s_d.hold     = vec_data_i;
                    s_d.ent_addr = {base_i, {BASE_SHIFT{1'b0}}} + ADDR_W'(wptr_i);
                    s_d.phase    = PH_W0;
                end
            end
            PH_W0, PH_W1, PH_W2, PH_W3: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = s_q.ent_addr + ADDR_W'(int'(widx) * WORD_BYTES);
                mem_wdata_o = word_sel[widx];
                if (s_q.phase == PH_W3) begin
                    commit_o  = 1'b1;
                    s_d.phase = wb_en_i ? PH_WB : PH_IDLE;
                end else begin
                    s_d.phase = phase_e'(s_q.phase + 3'd1);
                end
            end
            PH_WB: begin
                // pointer register already holds the committed value here
                mem_we_o    = 1'b1;
                mem_addr_o  = wb_addr_i;
                mem_wdata_o = {ovf_i, {PAD_W{1'b0}}, wptr_i};
                s_d.phase   = PH_IDLE;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase_o = s_q.phase;

endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
    import ivr_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int MAX_LOG2 = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              vec_valid,
    input  logic [127:0]      vec_data,
    output logic              vec_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              irq_out
);
    localparam int PTR_W  = MAX_LOG2 + 2;
    localparam int BASE_W = ADDR_W - BASE_SHIFT;

    logic              ring_en_w, irq_en_w, wb_en_w, ovf_clr_w, disable_w;
    logic              commit_w, ovf_w;
    logic [PTR_W-1:0]  mask_w, rptr_w, wptr_w;
    logic [BASE_W-1:0] base_w;
    logic [ADDR_W-1:0] wb_addr_w;
    phase_e            phase_w;

    ivr_regs #(
        .ADDR_W   (ADDR_W),
        .PTR_W    (PTR_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wptr_i    (wptr_w),
        .ovf_i     (ovf_w),
        .ring_en_o (ring_en_w),
        .irq_en_o  (irq_en_w),
        .wb_en_o   (wb_en_w),
        .ovf_clr_o (ovf_clr_w),
        .mask_o    (mask_w),
        .rptr_o    (rptr_w),
        .base_o    (base_w),
        .wb_addr_o (wb_addr_w),
        .disable_o (disable_w)
    );

    ivr_ptr #(
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_en_i (ring_en_w),
        .commit_i  (commit_w),
        .clear_i   (disable_w),
        .ovf_clr_i (ovf_clr_w),
        .rptr_i    (rptr_w),
        .mask_i    (mask_w),
        .wptr_o    (wptr_w),
        .ovf_o     (ovf_w)
    );

    ivr_seq #(
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_en_i   (ring_en_w),
        .wb_en_i     (wb_en_w),
        .vec_valid_i (vec_valid),
        .vec_data_i  (vec_data),
        .base_i      (base_w),
        .wptr_i      (wptr_w),
        .ovf_i       (ovf_w),
        .wb_addr_i   (wb_addr_w),
        .vec_ready_o (vec_ready),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .commit_o    (commit_w),
        .phase_o     (phase_w)
    );

    always_comb begin
        irq_out = irq_en_w & ring_en_w & ((wptr_w != rptr_w) | ovf_w);
    end

endmodule

// File: rtl/ivr_ring_writer_chk.sv
module ivr_ring_writer_chk
    import ivr_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int PTR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        phase,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              vec_ready,
    input logic              irq_out,
    input logic              ring_en,
    input logic              irq_en,
    input logic              ovf_clr,
    input logic              ovf,
    input logic [PTR_W-1:0]  wptr,
    input logic [PTR_W-1:0]  mask
);
    // R2: words of one entry land at consecutive word addresses
    a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (phase == 3'(PH_W1) || phase == 3'(PH_W2) || phase == 3'(PH_W3)))
        |-> mem_addr == $past(mem_addr) + ADDR_W'(4));

    // R4: an enabled ring moves its write pointer only by one slot modulo the mask
    a_r4_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_en && $past(ring_en) && wptr != $past(wptr))
        |-> wptr == (($past(wptr) + PTR_W'(16)) & $past(mask)));

    // R5: the overflow flag is sticky unless cleared or the ring is disabled
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf) && !$past(ovf_clr) && ring_en && $past(ring_en)) |-> ovf);

    // R6: the clear control forces the flag low on the next cycle
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> !ovf);

    // R8: no interrupt without both enables
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_en && ring_en));

    // R9: a disabled ring holds a zero pointer and no flag
    a_r9_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_en |-> (wptr == '0 && !ovf));

    // R10: ready never overlaps a memory write
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ready |-> !mem_we);

endmodule

bind ivr_ring_writer ivr_ring_writer_chk #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase_w),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .vec_ready (vec_ready),
    .irq_out   (irq_out),
    .ring_en   (ring_en_w),
    .irq_en    (irq_en_w),
    .ovf_clr   (ovf_clr_w),
    .ovf       (ovf_w),
    .wptr      (wptr_w),
    .mask      (mask_w)
);

// File: tb/ivr_ring_writer_tb.sv
module ivr_ring_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 40;
    localparam logic [AW-1:0] RING = 40'h00_ABCD_EF00;

    // vector, expected write pointer after storing it
    localparam logic [143:0] TAB [3] = '{
        {128'h0000_0000_0042_0305_0ABC_DEF1_0000_0077, 16'h0010},
        {128'hDEAD_BEEF_1234_5678_9ABC_DEF0_0F1E_2D3C, 16'h0020},
        {128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0001, 16'h0030}
    };

    logic          clk, rst_n;
    logic          reg_we;
    logic [2:0]    reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;
    logic          vec_valid;
    logic [127:0]  vec_data;
    logic          vec_ready, mem_we, irq_out;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [AW-1:0] log_a [64];
    logic [31:0]   log_d [64];
    int            log_total = 0;

    ivr_ring_writer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .vec_valid (vec_valid),
        .vec_data  (vec_data),
        .vec_ready (vec_ready),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .irq_out   (irq_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (mem_we === 1'b1) begin
            log_a[log_total % 64] = mem_addr;
            log_d[log_total % 64] = mem_wdata;
            log_total++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic [127:0] v, input logic [AW-1:0] ea, input bit wb,
                        input logic [AW-1:0] wa, input logic [31:0] wd);
        int start;
        start = log_total;
        @(negedge clk);
        vec_valid = 1'b1; vec_data = v;
        chk("R10 ready when idle", vec_ready, 1);
        @(negedge clk);
        vec_valid = 1'b0;
        chk("R10 not ready while writing", vec_ready, 0);
        repeat (6) @(negedge clk);
        chk("R2 word count", log_total - start, wb ? 5 : 4);
        for (int k = 0; k < 4; k++) begin
            chk("R2 R3 word address", log_a[(start + k) % 64], ea + AW'(4 * k));
            chk("R2 word data", log_d[(start + k) % 64], v[32*k +: 32]);
        end
        if (wb) begin
            chk("R7 mirror address", log_a[(start + 4) % 64], wa);
            chk("R7 mirror data", log_d[(start + 4) % 64], wd);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int start;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        vec_valid = 1'b0; vec_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, r); chk("R1 control", r, 0);
        rd(3'd3, r); chk("R1 write pointer", r, 0);
        rd(3'd2, r); chk("R1 read pointer", r, 0);
        chk("R1 ready", vec_ready, 0);
        chk("R1 irq", irq_out, 0);
        chk("R1 mem_we", mem_we, 0);

        // four-slot ring (size 4 -> 64 bytes), irq enabled
        wr(3'd1, 32'h00AB_CDEF);
        wr(3'd0, 32'h0000_0109);
        rd(3'd1, r); chk("R3 base readback", r, 32'h00AB_CDEF);

        for (int i = 0; i < 3; i++) begin
            send(TAB[i][143:16], RING + AW'(TAB[i][15:0] - 16'h10), 1'b0, '0, '0);
            rd(3'd3, r); chk("R4 pointer step", r, {16'h0, TAB[i][15:0]});
            chk("R8 irq with pending entries", irq_out, 1);
        end

        // R5 overflow: advancing lands on read pointer 0
        send(128'h1111_2222_3333_4444_5555_6666_7777_8888, RING + 40'h30, 1'b0, '0, '0);
        rd(3'd3, r); chk("R5 overflow flag set", r, 32'h8000_0000);
        chk("R8 irq on overflow with equal pointers", irq_out, 1);
        send(128'hA5A5_A5A5_5A5A_5A5A_0102_0304_0506_0708, RING, 1'b0, '0, '0);
        rd(3'd3, r); chk("R5 flag sticky", r, 32'h8000_0010);

        // R6 clear bit
        wr(3'd0, 32'h0000_0149);
        @(negedge clk);
        rd(3'd3, r); chk("R6 flag cleared", r, 32'h0000_0010);
        wr(3'd0, 32'h0000_0109);
        @(negedge clk);
        rd(3'd3, r); chk("R6 flag stays clear", r, 32'h0000_0010);

        // R8 equal pointers, no flag
        wr(3'd2, 32'h0000_0010);
        chk("R8 irq low when caught up", irq_out, 0);

        // R7 mirror write
        wr(3'd4, 32'h0000_4000);
        wr(3'd5, 32'h0000_0012);
        wr(3'd0, 32'h0000_0189);
        send(128'hCAFE_0000_BEEF_1111_2222_3333_4444_5555, RING + 40'h10, 1'b1,
             40'h12_0000_4000, 32'h0000_0020);
        rd(3'd3, r); chk("R4 pointer after mirror entry", r, 32'h0000_0020);

        // R6 suppression: reach the reader while the clear bit is held
        wr(3'd2, 32'h0000_0020);
        wr(3'd0, 32'h0000_0149);
        send(128'h1, RING + 40'h20, 1'b0, '0, '0);
        send(128'h2, RING + 40'h30, 1'b0, '0, '0);
        send(128'h3, RING + 40'h00, 1'b0, '0, '0);
        send(128'h4, RING + 40'h10, 1'b0, '0, '0);
        wr(3'd0, 32'h0000_0109);
        @(negedge clk);
        rd(3'd3, r); chk("R6 no overflow recorded while clearing", r, 32'h0000_0020);
        chk("R8 irq low with equal pointers and no flag", irq_out, 0);

        // R9 disable with entries pending
        send(128'h5, RING + 40'h20, 1'b0, '0, '0);
        wr(3'd0, 32'h0000_0108);
        rd(3'd3, r); chk("R9 write pointer zeroed", r, 0);
        rd(3'd2, r); chk("R9 read pointer zeroed", r, 0);
        chk("R9 ready low when disabled", vec_ready, 0);
        chk("R9 irq low when disabled", irq_out, 0);
        start = log_total;
        @(negedge clk);
        vec_valid = 1'b1; vec_data = 128'hBAD;
        repeat (6) @(negedge clk);
        vec_valid = 1'b0;
        chk("R9 no writes while disabled", log_total - start, 0);
        rd(3'd3, r); chk("R9 pointer unchanged while disabled", r, 0);

        // R4 wrap in a two-slot ring, R3 new base
        wr(3'd1, 32'h0000_0100);
        wr(3'd0, 32'h0000_0107);
        wr(3'd2, 32'h0000_0035);
        rd(3'd2, r); chk("R4 read pointer masked", r, 32'h0000_0015);
        wr(3'd2, 32'h0000_0000);
        send(128'h0F0F_0F0F_1E1E_1E1E_2D2D_2D2D_3C3C_3C3C, 40'h00_0001_0000, 1'b0, '0, '0);
        rd(3'd3, r); chk("R4 first slot", r, 32'h0000_0010);
        wr(3'd2, 32'h0000_0010);
        send(128'h7777_6666_5555_4444_3333_2222_1111_0000, 40'h00_0001_0010, 1'b0, '0, '0);
        rd(3'd3, r); chk("R4 wrap to zero", r, 32'h0000_0000);
        chk("R8 irq after wrap", irq_out, 1);
        wr(3'd0, 32'h0000_0007);
        chk("R8 irq masked by enable", irq_out, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule